// File: doc/BRIEF.md
# Mains-Locked Stepped Sine Generator

This block turns a 100 Hz reference pulse train, as produced by full-wave rectifying 50 Hz mains, into a 60 Hz stepped waveform whose timing follows the mains rather than a free-running crystal. A fast system clock measures the interval between reference rising edges. A remainder-carrying accumulator then places six evenly spread one-clock ticks inside each interval, which gives 600 Hz with no long-term drift.

The ticks clock a five-stage twisted-ring counter. Its five phase outputs are meant to be summed through resistors, and the block also reports the number of high stages as a binary level. That level climbs from 0 to 5 and falls back to 1 over ten ticks, so the staircase repeats at one tenth of the tick rate. The last stage gives a 60 Hz square wave.

If the reference disappears, the block raises a loss flag and keeps producing ticks from the last good period. When edges return, it locks again.

Top module: `mains_stair_gen`

## Requirements
- R1: After reset, tick600, lockLost, squareOut, stairLevel and every bit of ringPhase are 0.
- R2: No tick is produced until two reference rising edges have been seen after reset. If the period counter saturates (all ones) after only one edge, the block waits for two fresh edges again.
- R3: While locked to a steady reference period of P system clocks (P at least NUM_TICKS), exactly six one-clock ticks occur between consecutive reference rising edges.
- R4: While locked, the spacing between consecutive ticks is floor(P/6) or ceil(P/6). The first tick of each group is high in the clock cycle that follows the third rising clock edge after refPulse goes high.
- R5: On each tick the ring shifts one place toward higher bit numbers. Bit 0 takes the inverse of bit 4, so from all zeros the ring passes 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000 and returns to 00000.
- R6: stairLevel always equals the number of high ring bits, so it steps 0,1,2,3,4,5,4,3,2,1 over ten ticks.
- R7: squareOut equals ring bit 4: high for five ticks and low for five ticks, one period per ten ticks.
- R8: The ring, stairLevel and squareOut do not change in any cycle without a tick.
- R9: When a locked block sees no reference edge within twice the last measured period, or its period counter saturates, lockLost goes high. Ticks keep coming in groups of six per last good period, with the same spacing as in R4, and that period is not overwritten.
- R10: After a loss, lockLost stays high through the first returning edge and clears on the second one. From then on, the behaviour of R3 applies again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refPulse | input | 1 | 100 Hz reference pulse, asynchronous to clk |
| tick600 | output | 1 | One-clock tick, six per reference period |
| ringPhase | output | RING_LEN | Twisted-ring stage outputs, bit 0 first stage |
| stairLevel | output | clog2(RING_LEN+1) | Count of high ring stages |
| squareOut | output | 1 | Square wave from the last ring stage |
| lockLost | output | 1 | High while running on a held period |

## Verification
The bench drives a period that six divides evenly and one that it does not. A design that dropped the remainder would show the wrong tick count per period, or a gap outside floor and ceiling. Before lock, it waits once after a single edge and once after the period counter has saturated. A design that starts early, or that trusts a stale half-measurement, would tick there. During a reference outage it counts ticks over exactly three held periods, and during recovery it checks the flag edge by edge. This catches a generator that stalls, one that runs at a corrupted period, and one that clears the flag too soon. A cycle-by-cycle ring model catches wrong shift direction, a missing inversion or a ring that moves without a tick.

// File: rtl/mains_stair_pkg.sv
package mains_stair_pkg;

  typedef enum logic [2:0] {
    LK_WAIT_FIRST,
    LK_MEASURE,
    LK_LOCKED,
    LK_LOST,
    LK_RELOCK
  } lockState_e;

  typedef struct packed {
    logic restartCnt;
    logic loadPeriod;
    logic advance;
  } dpStrobe_t;

endpackage

// File: rtl/mains_stair_ctrl.sv
module mains_stair_ctrl
  import mains_stair_pkg::*;
#(
  parameter int CNT_W     = 20,
  parameter int NUM_TICKS = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refPulse,
  input  logic [CNT_W-1:0] periodCnt,
  input  logic [CNT_W-1:0] periodReg,
  input  logic             cntOverflow,
  output dpStrobe_t        strobe,
  output logic             tick,
  output logic             lockLost
);
  localparam int ACC_W = CNT_W + 1;
  localparam int TL_W  = $clog2(NUM_TICKS);

  // reference synchroniser and rising-edge detect
  logic [1:0] refSync;
  logic       refPrev;
  logic       refEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refSync <= '0;
      refPrev <= 1'b0;
    end else begin
      refSync <= {refSync[0], refPulse};
      refPrev <= refSync[1];
    end
  end

  assign refEdge = refSync[1] & ~refPrev;

  // lock state machine
  lockState_e state, stateNext;
  logic       missingEdge, lossEvent;
  logic       restartCnt, loadPeriod, realStart, enterLost;

  assign missingEdge = {1'b0, periodCnt} >= {periodReg, 1'b0};
  assign lossEvent   = cntOverflow | missingEdge;

  always_comb begin
    stateNext  = state;
    restartCnt = 1'b0;
    loadPeriod = 1'b0;
    realStart  = 1'b0;
    enterLost  = 1'b0;
    case (state)
      LK_WAIT_FIRST: begin
        if (refEdge) begin
          restartCnt = 1'b1;
          stateNext  = LK_MEASURE;
        end
      end
      LK_MEASURE: begin
        if (refEdge) begin
          restartCnt = 1'b1;
          loadPeriod = 1'b1;
          realStart  = 1'b1;
          stateNext  = LK_LOCKED;
        end else if (cntOverflow) begin
          stateNext = LK_WAIT_FIRST;
        end
      end
      LK_LOCKED: begin
        if (refEdge) begin
          restartCnt = 1'b1;
          loadPeriod = 1'b1;
          realStart  = 1'b1;
        end else if (lossEvent) begin
          enterLost = 1'b1;
          stateNext = LK_LOST;
        end
      end
      LK_LOST: begin
        if (refEdge) begin
          restartCnt = 1'b1;
          realStart  = 1'b1;
          stateNext  = LK_RELOCK;
        end
      end
      LK_RELOCK: begin
        if (refEdge) begin
          restartCnt = 1'b1;
          loadPeriod = 1'b1;
          realStart  = 1'b1;
          stateNext  = LK_LOCKED;
        end else if (lossEvent) begin
          stateNext = LK_LOST;
        end
      end
      default: stateNext = LK_WAIT_FIRST;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= LK_WAIT_FIRST;
    else       state <= stateNext;
  end

  assign lockLost = (state == LK_LOST) || (state == LK_RELOCK);

  // tick generator: remainder-carrying accumulator, capped burst per period
  logic [ACC_W-1:0] acc, accSum;
  logic [TL_W-1:0]  ticksLeft;
  logic [CNT_W-1:0] phaseCnt;
  logic             freeRun, startBurst, accHit, tickQ;

  assign freeRun    = lockLost && (phaseCnt >= periodReg);
  assign startBurst = realStart | enterLost | freeRun;
  assign accSum     = acc + ACC_W'(NUM_TICKS);
  assign accHit     = (ticksLeft != '0) && (accSum >= {1'b0, periodReg});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      ticksLeft <= '0;
      phaseCnt  <= '0;
      tickQ     <= 1'b0;
    end else if (startBurst) begin
      acc       <= '0;
      ticksLeft <= TL_W'(NUM_TICKS - 1);
      phaseCnt  <= CNT_W'(1);
      tickQ     <= 1'b1;
    end else begin
      tickQ <= accHit;
      if (ticksLeft != '0) begin
        acc <= accHit ? (accSum - {1'b0, periodReg}) : accSum;
      end
      if (accHit) ticksLeft <= ticksLeft - 1'b1;
      if (!(&phaseCnt)) phaseCnt <= phaseCnt + 1'b1;
    end
  end

  assign tick              = tickQ;
  assign strobe.restartCnt = restartCnt;
  assign strobe.loadPeriod = loadPeriod;
  assign strobe.advance    = tickQ;

  AST_NO_TICK_BEFORE_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    ((state == LK_WAIT_FIRST) || (state == LK_MEASURE)) |-> !tickQ); // R2
  AST_TICK_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (tickQ && (ticksLeft == '0) && !startBurst) |=> !tickQ); // R3
  AST_LOST_ON_MISSING: assert property (@(posedge clk) disable iff (!rstN)
    ((state == LK_LOCKED) && !refEdge && lossEvent) |=> lockLost); // R9
  AST_RELOCK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ((state == LK_RELOCK) && refEdge) |=> !lockLost); // R10

endmodule

// File: rtl/mains_stair_dp.sv
module mains_stair_dp
  import mains_stair_pkg::*;
#(
  parameter int CNT_W    = 20,
  parameter int RING_LEN = 5,
  parameter int STAIR_W  = $clog2(RING_LEN + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  output logic [CNT_W-1:0]    periodCnt,
  output logic [CNT_W-1:0]    periodReg,
  output logic                cntOverflow,
  output logic [RING_LEN-1:0] ringPhase,
  output logic [STAIR_W-1:0]  stairLevel
);
  // period counter: clocks since last accepted edge, saturating
  logic [CNT_W-1:0] cntQ, perQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  cntQ <= '0;
    else if (strobe.restartCnt) cntQ <= CNT_W'(1);
    else if (!(&cntQ))          cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  perQ <= '1;
    else if (strobe.loadPeriod) perQ <= cntQ;
  end

  assign periodCnt   = cntQ;
  assign periodReg   = perQ;
  assign cntOverflow = &cntQ;

  // twisted ring, one flop per stage
  logic [RING_LEN-1:0] ringQ;

  for (genvar g = 0; g < RING_LEN; g++) begin : gStage
    logic stageIn;
    if (g == 0) begin : gHead
      assign stageIn = ~ringQ[RING_LEN-1];
    end else begin : gBody
      assign stageIn = ringQ[g-1];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               ringQ[g] <= 1'b0;
      else if (strobe.advance) ringQ[g] <= stageIn;
    end
  end

  always_comb begin
    stairLevel = '0;
    for (int i = 0; i < RING_LEN; i++) stairLevel = stairLevel + STAIR_W'(ringQ[i]);
  end

  assign ringPhase = ringQ;

  AST_RING_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ringQ ^ {ringQ[RING_LEN-2:0], ringQ[RING_LEN-1]}) <= 2); // R5
  AST_RING_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> $stable(ringQ)); // R8
  AST_STAIR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> ((stairLevel == $past(stairLevel) + 1'b1) ||
                        (stairLevel + 1'b1 == $past(stairLevel)))); // R6
  AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadPeriod |=> $stable(perQ)); // R9

endmodule

// File: rtl/mains_stair_gen.sv
module mains_stair_gen
  import mains_stair_pkg::*;
#(
  parameter int CNT_W     = 20,
  parameter int NUM_TICKS = 6,
  parameter int RING_LEN  = 5,
  localparam int STAIR_W  = $clog2(RING_LEN + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                refPulse,
  output logic                tick600,
  output logic [RING_LEN-1:0] ringPhase,
  output logic [STAIR_W-1:0]  stairLevel,
  output logic                squareOut,
  output logic                lockLost
);
  dpStrobe_t        strobe;
  logic [CNT_W-1:0] periodCnt, periodReg;
  logic             cntOverflow;

  mains_stair_ctrl #(.CNT_W(CNT_W), .NUM_TICKS(NUM_TICKS)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .refPulse    (refPulse),
    .periodCnt   (periodCnt),
    .periodReg   (periodReg),
    .cntOverflow (cntOverflow),
    .strobe      (strobe),
    .tick        (tick600),
    .lockLost    (lockLost)
  );

  mains_stair_dp #(.CNT_W(CNT_W), .RING_LEN(RING_LEN), .STAIR_W(STAIR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .periodCnt   (periodCnt),
    .periodReg   (periodReg),
    .cntOverflow (cntOverflow),
    .ringPhase   (ringPhase),
    .stairLevel  (stairLevel)
  );

  assign squareOut = ringPhase[RING_LEN-1];

  AST_SQUARE_TOGGLES_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tick600 |=> $stable(squareOut)); // R7

endmodule

// File: tb/mains_stair_gen_tb.sv
module mains_stair_gen_tb;
  localparam int CNT_W = 12;
  localparam int NT    = 6;
  localparam int RL    = 5;
  localparam int SW    = $clog2(RL + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          refPulse = 1'b0;
  logic          tick600, squareOut, lockLost;
  logic [RL-1:0] ringPhase;
  logic [SW-1:0] stairLevel;

  mains_stair_gen #(.CNT_W(CNT_W), .NUM_TICKS(NT), .RING_LEN(RL)) u_dut (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .tick600(tick600),
    .ringPhase(ringPhase), .stairLevel(stairLevel), .squareOut(squareOut),
    .lockLost(lockLost)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0, fails = 0, cyc = 0;
  int tickTotal = 0, lastTickCyc = -1, gapMin = 0, gapMax = 0;
  int refSeenCyc = 0, lastLat = -1;
  bit firstPending = 0, refPrevTb = 0, done = 0;
  logic [RL-1:0] modelRing = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int popc(input logic [RL-1:0] v);
    int n = 0;
    for (int i = 0; i < RL; i++) n += int'(v[i]);
    return n;
  endfunction

  // monitor: compare against the ring model, then count ticks
  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      modelRing = '0; tickTotal = 0; firstPending = 0; lastTickCyc = -1;
    end else begin
      chk(ringPhase == modelRing, "R5", "ring pattern", int'(ringPhase), int'(modelRing)); // R8 too
      chk(int'(stairLevel) == popc(modelRing), "R6", "stair level", int'(stairLevel), popc(modelRing));
      chk(squareOut == modelRing[RL-1], "R7", "square output", int'(squareOut), int'(modelRing[RL-1]));
      if (refPulse && !refPrevTb) begin
        refSeenCyc = cyc; firstPending = 1;
      end
      if (tick600) begin
        if (lastTickCyc >= 0) begin
          if (cyc - lastTickCyc < gapMin) gapMin = cyc - lastTickCyc;
          if (cyc - lastTickCyc > gapMax) gapMax = cyc - lastTickCyc;
        end
        lastTickCyc = cyc;
        tickTotal++;
        if (firstPending) begin
          lastLat = cyc - refSeenCyc; firstPending = 0;
        end
        modelRing = {modelRing[RL-2:0], ~modelRing[RL-1]};
      end
    end
    refPrevTb = refPulse;
  end

  always @(posedge clk) begin
    if (!done && cyc > 190000) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic resetGaps();
    gapMin = 1 << 30; gapMax = 0; lastTickCyc = -1;
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk); #1; refPulse = 1'b0;
    end
  endtask

  task automatic pulses(input int period, input int n);
    for (int i = 0; i < n; i++)
      for (int c = 0; c < period; c++) begin
        @(negedge clk); #1; refPulse = (c < 40);
      end
  endtask

  task automatic doReset();
    rstN = 1'b0; refPulse = 1'b0;
    repeat (4) @(negedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic testReset();
    doReset();
    @(negedge clk); #1;
    chk(tick600 == 1'b0, "R1", "tick after reset", int'(tick600), 0);
    chk(ringPhase == '0, "R1", "ring after reset", int'(ringPhase), 0);
    chk(stairLevel == '0, "R1", "stair after reset", int'(stairLevel), 0);
    chk(squareOut == 1'b0, "R1", "square after reset", int'(squareOut), 0);
    chk(lockLost == 1'b0, "R1", "loss flag after reset", int'(lockLost), 0);
  endtask

  task automatic testStartup();
    int t0;
    pulses(600, 1);
    chk(tickTotal == 0, "R2", "ticks after one edge", tickTotal, 0);
    idle(4300);  // period counter saturates at 4095
    pulses(600, 1);
    chk(tickTotal == 0, "R2", "ticks after overflow and one edge", tickTotal, 0);
    chk(lockLost == 1'b0, "R2", "loss flag before lock", int'(lockLost), 0);
    t0 = tickTotal;
    pulses(600, 1);
    chk(tickTotal - t0 == 6, "R2", "ticks once second edge seen", tickTotal - t0, 6);
  endtask

  task automatic testLocked(input int p);
    int t0;
    pulses(p, 2);  // settle onto the new period
    resetGaps();
    for (int i = 0; i < 4; i++) begin
      t0 = tickTotal;
      pulses(p, 1);
      chk(tickTotal - t0 == 6, "R3", "ticks per period", tickTotal - t0, 6);
      chk(lastLat == 2, "R4", "edge to first tick", lastLat, 2);
    end
    chk(gapMin == p / 6, "R4", "shortest gap", gapMin, p / 6);
    chk(gapMax == (p + 5) / 6, "R4", "longest gap", gapMax, (p + 5) / 6);
  endtask

  task automatic testLoss();
    int t0;
    idle(1400);
    chk(lockLost == 1'b1, "R9", "flag after missing edge", int'(lockLost), 1);
    resetGaps();
    t0 = tickTotal;
    idle(3 * 605);
    chk(tickTotal - t0 == 18, "R9", "held-period ticks in three periods", tickTotal - t0, 18);
    chk(gapMin >= 100, "R9", "held shortest gap", gapMin, 100);
    chk(gapMax <= 101, "R9", "held longest gap", gapMax, 101);
    pulses(605, 1);
    chk(lockLost == 1'b1, "R10", "flag after first returning edge", int'(lockLost), 1);
    pulses(605, 1);
    chk(lockLost == 1'b0, "R10", "flag after second returning edge", int'(lockLost), 0);
    t0 = tickTotal;
    pulses(605, 1);
    chk(tickTotal - t0 == 6, "R10", "ticks per period after relock", tickTotal - t0, 6);
  endtask

  initial begin
    testReset();
    testStartup();
    testLocked(600);
    testLocked(605);
    testLoss();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule